// File: doc/BRIEF.md
# Serial Port Transmit/Receive Queue Pair

This block sits between a host register interface and the shift engine of a synchronous serial port. It holds two queues, each sixteen words deep. Transmit words flow from host writes to serial-side pops. Received words flow from serial-side pushes to host reads. Both queues present their oldest word combinationally at the head, so a pop or read strobe consumes the word that is visible in that cycle.

A six-bit control word holds three fields. Bit 0 is the transmit enable, which drives the serial-side transmit request. Bit 1 is a level-held transmit queue reset. Bits 5:2 are the receive threshold code. A status word reports three flags and the occupancy of both queues. The flags are a sticky transmit underrun error, a transmit-empty flag and a receive-ready flag. The receive-ready flag is set when the receive occupancy reaches the programmed threshold.

The transmit queue reset is a held condition and not a pulse. While the bit reads 1, the block does the following:
- It flushes the queue on every cycle.
- It ignores host writes.
- It offers no valid word to the serial side.
- It holds the error flag at 0.

The reset leaves the transmit enable untouched.

Top module: `sio_fifo_pair`

## Requirements
- R1: After `rst_n` is released, the following hold: the control word reads 0, `ser_tx_req` is 0, `ser_tx_valid` is 0, status bit 0 (tx error) is 0, status bit 1 (tx empty) is 1, status bit 2 (rx ready) is 0, and both level fields are 0. The tx level field is status bits 7:3 and the rx level field is status bits 12:8.
- R2: The transmit queue delivers host-written words to `ser_tx_data` in write order and holds up to DEPTH words. While the queue is full, host writes are ignored. `ser_tx_valid` is 1 exactly when the queue holds a word and the reset bit is 0.
- R3: While control bit 1 (tx reset) is 1, the transmit queue behaves as follows:
  - Status tx empty reads 1 from the cycle after the bit is written.
  - The tx level reads 0 from the cycle after that.
  - Host writes are ignored.
  - `ser_tx_valid` is 0.
  - When the bit is cleared, the queue remains empty.
- R4: Holding the tx reset bit returns the tx error flag to 0, and the flag stays 0 while the bit is held.
- R5: `ser_tx_req` follows control bit 0 (tx enable). Setting or clearing the tx reset bit does not change it.
- R6: A serial pop while the transmit queue is empty and the reset bit is 0 sets the tx error flag on the next cycle. The flag then stays 1 until a tx reset.
- R7: The receive queue delivers pushed words to `host_rx_data` in push order. A host read while the queue is empty has no effect.
- R8: A push into a receive queue that holds DEPTH words is dropped, and the level and head word are unchanged.
- R9: For threshold code k in control bits 5:2, rx ready equals (rx level >= k+1). The default code 0 gives a threshold of one word.
- R10: rx ready falls in the cycle after a host read takes the level below the threshold. A new threshold code applies from the cycle after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_tx_wr | input | 1 | Host write strobe for the transmit queue |
| host_tx_data | input | WIDTH | Host transmit word |
| host_rx_rd | input | 1 | Host read strobe, pops the receive queue |
| host_rx_data | output | WIDTH | Oldest receive word |
| host_ctl_wr | input | 1 | Control word write strobe |
| host_ctl_wdata | input | 6 | Control write data: bit 0 enable, bit 1 tx reset, bits 5:2 threshold code |
| host_ctl_rdata | output | 6 | Current control word |
| host_status | output | 3+2*LW | Status: bit 0 tx error, bit 1 tx empty, bit 2 rx ready, tx level, rx level |
| ser_tx_req | output | 1 | Transmit request to the shift engine |
| ser_tx_pop | input | 1 | Shift engine takes the head transmit word |
| ser_tx_data | output | WIDTH | Oldest transmit word |
| ser_tx_valid | output | 1 | Head transmit word is valid |
| ser_rx_push | input | 1 | Shift engine delivers a received word |
| ser_rx_data | input | WIDTH | Received word |

## Verification
The bench builds the block with DEPTH 16 and WIDTH 8. At that size, every one of the sixteen threshold codes can be swept against every receive occupancy from 0 to 16, both while the queue fills and while it drains. The depth also lets the bench drive both queues into the full state and through the overflow and underrun edges. Each sweep step is checked against a threshold of code plus one, computed in the bench.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int unsigned WM_W  = 4;
  localparam int unsigned CTL_W = 2 + WM_W;

  // Threshold in words selected by a code: code plus one.
  function automatic int unsigned wm_words(input logic [WM_W-1:0] code);
    return int'(code) + 1;
  endfunction

  // Receive-ready condition for a given occupancy and code.
  function automatic logic level_meets(input int unsigned level,
                                       input logic [WM_W-1:0] code);
    return level >= wm_words(code);
  endfunction
endpackage

// File: rtl/sfp_queue.sv
module sfp_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] head,
  output logic [LW-1:0]    level,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
  assign wr_ok = wr_en & ~full & ~flush;
  assign rd_ok = rd_en & ~empty & ~flush;
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sfp_ctl.sv
module sfp_ctl
  import sfp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic             tx_en,
  output logic             tx_rst,
  output logic [WM_W-1:0]  wm_code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en   <= 1'b0;
      tx_rst  <= 1'b0;
      wm_code <= '0;
    end else if (wr) begin
      tx_en   <= wdata[0];
      tx_rst  <= wdata[1];
      wm_code <= wdata[CTL_W-1:2];
    end
  end
endmodule

// File: rtl/sfp_flags.sv
module sfp_flags
  import sfp_pkg::*;
#(
  parameter int unsigned LW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_rst,
  input  logic            tx_pop,
  input  logic            tx_q_empty,
  input  logic [LW-1:0]   rx_level,
  input  logic [WM_W-1:0] wm_code,
  output logic            tx_underrun,
  output logic            tx_err,
  output logic            rx_ready
);
  assign tx_underrun = tx_pop & tx_q_empty & ~tx_rst;
  assign rx_ready    = level_meets(int'(rx_level), wm_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tx_err <= 1'b0;
    else if (tx_rst)      tx_err <= 1'b0;
    else if (tx_underrun) tx_err <= 1'b1;
  end
endmodule

// File: rtl/sio_fifo_pair.sv
module sio_fifo_pair
  import sfp_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned SW = 3 + 2 * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_tx_wr,
  input  logic [WIDTH-1:0] host_tx_data,
  input  logic             host_rx_rd,
  output logic [WIDTH-1:0] host_rx_data,
  input  logic             host_ctl_wr,
  input  logic [CTL_W-1:0] host_ctl_wdata,
  output logic [CTL_W-1:0] host_ctl_rdata,
  output logic [SW-1:0]    host_status,
  output logic             ser_tx_req,
  input  logic             ser_tx_pop,
  output logic [WIDTH-1:0] ser_tx_data,
  output logic             ser_tx_valid,
  input  logic             ser_rx_push,
  input  logic [WIDTH-1:0] ser_rx_data
);
  logic            tx_en, tx_rst;
  logic [WM_W-1:0] wm_code;
  logic [LW-1:0]   tx_level, rx_level;
  logic            tx_wr_ok, tx_rd_ok, tx_q_empty, tx_q_full;
  logic            rx_wr_ok, rx_rd_ok, rx_q_empty, rx_q_full;
  logic            tx_underrun, tx_err, rx_ready, tx_empty_flag;

  sfp_ctl ctl_i (
    .clk, .rst_n, .wr(host_ctl_wr), .wdata(host_ctl_wdata),
    .tx_en, .tx_rst, .wm_code
  );

  sfp_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) txq_i (
    .clk, .rst_n, .flush(tx_rst),
    .wr_en(host_tx_wr), .wr_data(host_tx_data),
    .rd_en(ser_tx_pop), .head(ser_tx_data), .level(tx_level),
    .wr_ok(tx_wr_ok), .rd_ok(tx_rd_ok), .empty(tx_q_empty), .full(tx_q_full)
  );

  sfp_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) rxq_i (
    .clk, .rst_n, .flush(1'b0),
    .wr_en(ser_rx_push), .wr_data(ser_rx_data),
    .rd_en(host_rx_rd), .head(host_rx_data), .level(rx_level),
    .wr_ok(rx_wr_ok), .rd_ok(rx_rd_ok), .empty(rx_q_empty), .full(rx_q_full)
  );

  sfp_flags #(.LW(LW)) flags_i (
    .clk, .rst_n, .tx_rst, .tx_pop(ser_tx_pop), .tx_q_empty,
    .rx_level, .wm_code, .tx_underrun, .tx_err, .rx_ready
  );

  assign tx_empty_flag  = tx_q_empty | tx_rst;
  assign ser_tx_req     = tx_en;
  assign ser_tx_valid   = ~tx_q_empty & ~tx_rst;
  assign host_ctl_rdata = {wm_code, tx_rst, tx_en};
  assign host_status    = {rx_level, tx_level, rx_ready, tx_empty_flag, tx_err};
endmodule

// File: rtl/sfp_chk.sv
module sfp_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_rst,
  input logic          tx_en,
  input logic          ser_tx_req,
  input logic          ser_tx_pop,
  input logic          ser_tx_valid,
  input logic          tx_q_empty,
  input logic          tx_err,
  input logic          tx_underrun,
  input logic          host_tx_wr,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          ser_rx_push,
  input logic          host_rx_rd
);
  // R3
  tx_flush_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rst && $past(tx_rst)) |-> (tx_level == '0 && !ser_tx_valid));

  // R4
  tx_err_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_rst) |-> !tx_err);

  // R6
  tx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_tx_pop && tx_q_empty && !tx_rst) |=> tx_err);

  // R8
  rx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rx_push && !host_rx_rd && rx_level == LW'(DEPTH)) |=> rx_level == LW'(DEPTH));

  // R2
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH));

  // R5
  tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_tx_req == tx_en);

  // R2
  tx_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tx_wr && !ser_tx_pop && !tx_rst && tx_level == LW'(DEPTH)) |=> tx_level == LW'(DEPTH));
endmodule

bind sio_fifo_pair sfp_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .tx_en(tx_en),
  .ser_tx_req(ser_tx_req), .ser_tx_pop(ser_tx_pop), .ser_tx_valid(ser_tx_valid),
  .tx_q_empty(tx_q_empty), .tx_err(tx_err), .tx_underrun(tx_underrun),
  .host_tx_wr(host_tx_wr), .tx_level(tx_level), .rx_level(rx_level),
  .ser_rx_push(ser_rx_push), .host_rx_rd(host_rx_rd)
);

// File: tb/sio_fifo_pair_tb_top.sv
module sio_fifo_pair_tb_top;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int SW = 3 + 2 * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_tx_wr = 1'b0;
  logic [WIDTH-1:0] host_tx_data = '0;
  logic host_rx_rd = 1'b0;
  logic [WIDTH-1:0] host_rx_data;
  logic host_ctl_wr = 1'b0;
  logic [5:0] host_ctl_wdata = '0;
  logic [5:0] host_ctl_rdata;
  logic [SW-1:0] host_status;
  logic ser_tx_req;
  logic ser_tx_pop = 1'b0;
  logic [WIDTH-1:0] ser_tx_data;
  logic ser_tx_valid;
  logic ser_rx_push = 1'b0;
  logic [WIDTH-1:0] ser_rx_data = '0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sio_fifo_pair #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (.*);

  function automatic int st_err();   return int'(host_status[0]); endfunction
  function automatic int st_empty(); return int'(host_status[1]); endfunction
  function automatic int st_ready(); return int'(host_status[2]); endfunction
  function automatic int st_txlvl(); return int'(host_status[3 +: LW]); endfunction
  function automatic int st_rxlvl(); return int'(host_status[3 + LW +: LW]); endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ctl(input bit en, input bit rs, input int code);
    host_ctl_wr = 1'b1;
    host_ctl_wdata = {code[3:0], rs, en};
    step();
    host_ctl_wr = 1'b0;
  endtask

  task automatic tx_write(input int d);
    host_tx_wr = 1'b1;
    host_tx_data = WIDTH'(d);
    step();
    host_tx_wr = 1'b0;
  endtask

  task automatic tx_pop();
    ser_tx_pop = 1'b1;
    step();
    ser_tx_pop = 1'b0;
  endtask

  task automatic rx_push(input int d);
    ser_rx_push = 1'b1;
    ser_rx_data = WIDTH'(d);
    step();
    ser_rx_push = 1'b0;
  endtask

  task automatic rx_read();
    host_rx_rd = 1'b1;
    step();
    host_rx_rd = 1'b0;
  endtask

  function automatic int pat(input int k, input int n);
    return (k * 37 + n * 11 + 5) & 8'hFF;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    check("R1 ctl", int'(host_ctl_rdata), 0);
    check("R1 req", int'(ser_tx_req), 0);
    check("R1 valid", int'(ser_tx_valid), 0);
    check("R1 err", st_err(), 0);
    check("R1 empty", st_empty(), 1);
    check("R1 ready", st_ready(), 0);
    check("R1 txlvl", st_txlvl(), 0);
    check("R1 rxlvl", st_rxlvl(), 0);

    // R2 fill transmit queue, one extra write ignored
    for (int i = 0; i < DEPTH; i++) tx_write(pat(1, i));
    check("R2 full level", st_txlvl(), DEPTH);
    tx_write(8'hA5);
    check("R2 write when full", st_txlvl(), DEPTH);
    check("R2 not empty", st_empty(), 0);
    for (int i = 0; i < DEPTH; i++) begin
      check("R2 valid", int'(ser_tx_valid), 1);
      check("R2 order", int'(ser_tx_data), pat(1, i));
      tx_pop();
    end
    check("R2 drained", st_txlvl(), 0);
    check("R2 empty", st_empty(), 1);
    check("R2 valid low", int'(ser_tx_valid), 0);
    check("R6 no err yet", st_err(), 0);

    // R6 underrun
    tx_pop();
    check("R6 err set", st_err(), 1);
    repeat (3) step();
    check("R6 sticky", st_err(), 1);

    // R5 enable, R3/R4 held reset
    ctl(1'b1, 1'b0, 0);
    check("R5 req on", int'(ser_tx_req), 1);
    for (int i = 0; i < 5; i++) tx_write(pat(2, i));
    check("R3 pre level", st_txlvl(), 5);
    ctl(1'b1, 1'b1, 0);
    check("R3 empty flag", st_empty(), 1);
    check("R3 valid off", int'(ser_tx_valid), 0);
    check("R5 req kept", int'(ser_tx_req), 1);
    step();
    check("R3 level cleared", st_txlvl(), 0);
    check("R4 err cleared", st_err(), 0);
    tx_write(8'h3C);
    check("R3 write ignored", st_txlvl(), 0);
    check("R3 valid held", int'(ser_tx_valid), 0);
    tx_pop();
    check("R4 err held", st_err(), 0);
    ctl(1'b1, 1'b0, 0);
    check("R3 released level", st_txlvl(), 0);
    check("R3 released empty", st_empty(), 1);
    check("R5 req after", int'(ser_tx_req), 1);
    check("R4 err after", st_err(), 0);
    tx_write(8'h77);
    check("R3 works again", int'(ser_tx_data), 8'h77);
    tx_pop();
    ctl(1'b0, 1'b0, 0);
    check("R5 req off", int'(ser_tx_req), 0);

    // R7 read of empty receive queue
    rx_read();
    check("R7 empty read", st_rxlvl(), 0);

    // R9/R8/R10 exhaustive threshold sweep
    for (int k = 0; k < 16; k++) begin
      ctl(1'b0, 1'b0, k);
      check("R9 code readback", int'(host_ctl_rdata[5:2]), k);
      check("R9 empty ready", st_ready(), 0);
      for (int n = 1; n <= DEPTH; n++) begin
        rx_push(pat(k, n));
        check("R9 level", st_rxlvl(), n);
        check("R9 ready fill", st_ready(), (n >= k + 1) ? 1 : 0);
      end
      rx_push(8'hEE);
      check("R8 drop level", st_rxlvl(), DEPTH);
      check("R8 drop head", int'(host_rx_data), pat(k, 1));
      for (int n = DEPTH; n >= 1; n--) begin
        check("R7 order", int'(host_rx_data), pat(k, DEPTH + 1 - n));
        rx_read();
        check("R10 ready drain", st_ready(), (n - 1 >= k + 1) ? 1 : 0);
      end
      check("R7 drained", st_rxlvl(), 0);
    end

    // R10 threshold change
    for (int i = 0; i < 4; i++) rx_push(i);
    ctl(1'b0, 1'b0, 3);
    check("R10 code 3", st_ready(), 1);
    ctl(1'b0, 1'b0, 4);
    check("R10 code 4", st_ready(), 0);
    ctl(1'b0, 1'b0, 0);
    check("R9 default", st_ready(), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule